// File: doc/BRIEF.md
# Snapshot Read Register Bank

This block is a small register bank on an 8-bit read/write port. It holds one 32-bit event counter that is read as four byte-wide sub-words. It also holds a read/write scratch register, called the arm register, and two 8-bit status registers. The counter and both status registers each have a snapshot buffer. A snapshot buffer copies the live field values when its trigger fires, and a CPU read of that register returns the copy instead of the live value. Software can therefore read a multi-byte or multi-register view that was taken in a single clock cycle.

Each buffered register has its own trigger. The counter triggers itself: a read of its lowest byte returns that byte live and freezes the whole count, so the three upper bytes read afterwards belong to the same value. Status A is frozen by a read of the arm register. Status B follows an external sample input of configurable polarity. Read side effects happen in the cycle the snapshot is taken, not in the cycle the bus reads the buffered register. These side effects are the counter's clear on capture and the software-access pulses.

Top module: `rsnap_bank`

## Requirements
- R1: After reset, the counter, every snapshot buffer, the arm register, `rdata_o` and `rd_valid_o` are zero.
- R2: A read request returns its data on `rdata_o`, with `rd_valid_o` high, in the cycle after the request. In any other cycle `rdata_o` is zero. A read of an address above 6 returns zero.
- R3: The counter increases by one on every clock edge at which `cnt_en_i` is high.
- R4: A read of address 0 returns counter bits 7:0 live and, on the same edge, copies all 32 counter bits into the counter snapshot. Reads of addresses 1, 2 and 3 return snapshot bits 15:8, 23:16 and 31:24.
- R5: When the counter snapshot is taken, the counter becomes 1 if `cnt_en_i` is high in that cycle and 0 otherwise. Reads of addresses 1 to 3 neither clear the counter nor reload the snapshot.
- R6: `cnt_acc_o` is high exactly in the cycles that carry a read request to address 0.
- R7: A read request to address 4 (the arm register) copies status A into its snapshot, and `sta_acc_o` is high in that cycle. A read of address 5 returns the snapshot, does not raise `sta_acc_o` and does not reload the snapshot.
- R8: In the status A snapshot, bit k for k = 0..3 equals `sta_lo_i[3-k]`, bits 6:4 equal `sta_hi_i`, and bit 7 is zero.
- R9: The status B snapshot loads `stb_i` on every clock edge at which `snap_i` is at its active level (high when `SNAP_ACTIVE_HIGH` is 1). Otherwise it holds its value, and address 6 returns it.
- R10: Address 4 is an 8-bit read/write register. Writes to any other address change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read request |
| wr_en_i | input | 1 | Write request |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| cnt_en_i | input | 1 | Counter increment enable |
| cnt_acc_o | output | 1 | Counter software-access pulse, at snapshot time |
| sta_lo_i | input | 4 | Status A low field, declared in reversed bit order |
| sta_hi_i | input | 3 | Status A high field |
| sta_acc_o | output | 1 | Status A software-access pulse, at snapshot time |
| stb_i | input | BUS_W | Status B live value |
| snap_i | input | 1 | External sample input for status B |

## Verification
A snapshot that loads on the wrong cycle shows up as an upper counter byte that does not match the byte-0 value read before it. It also shows up as a status byte that reflects inputs changed after the trigger, and it is visible on the very next read of the buffered address. A wrong clear point shows up as a count after capture that is off by the events of one cycle. An access pulse raised by the wrong address shows up at the pulse ports in the same cycle as the bad read. The bench changes the live inputs between the trigger and the buffered read, so that any of these faults changes the returned byte.

// File: rtl/rsnap_pkg.sv
package rsnap_pkg;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CNT,
      TGT_ARM,
      TGT_STA,
      TGT_STB
   } rsnap_tgt_e;

endpackage

// File: rtl/rsnap_counter.sv
module rsnap_counter #(
   parameter int unsigned W              = 32,
   parameter bit          CLR_ON_CAPTURE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic         capture_i,
   output logic [W-1:0] count_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   generate
      if (CLR_ON_CAPTURE) begin : g_clr
         always_comb begin
            if (capture_i)  cnt_d = inc_i ? W'(1) : '0;
            else if (inc_i) cnt_d = cnt_q + W'(1);
            else            cnt_d = cnt_q;
         end
      end else begin : g_keep
         always_comb cnt_d = inc_i ? cnt_q + W'(1) : cnt_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

   // R5: capture restarts the count from the event of that cycle
   p_clear_at_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CLR_ON_CAPTURE && capture_i) |=> (count_o == ($past(inc_i) ? W'(1) : W'(0))));

   // R3: no event, no capture, no change
   p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !capture_i) |=> $stable(count_o));

endmodule

// File: rtl/rsnap_buffer.sv
module rsnap_buffer #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     snap_q <= '0;
      else if (load_i) snap_q <= d_i;
   end

   assign q_o = snap_q;

   // R7, R9: a snapshot only moves on its trigger
   p_hold_without_trigger_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(q_o));

endmodule

// File: rtl/rsnap_bank.sv
module rsnap_bank
   import rsnap_pkg::*;
#(
   parameter int unsigned BUS_W            = 8,
   parameter int unsigned CNT_W            = 32,
   parameter int unsigned ADDR_W           = 3,
   parameter int unsigned STA_LO_W         = 4,
   parameter int unsigned STA_HI_W         = 3,
   parameter bit          SNAP_ACTIVE_HIGH = 1'b1,
   parameter bit          CNT_CLR_ON_READ  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   output logic              rd_valid_o,
   input  logic              cnt_en_i,
   output logic              cnt_acc_o,
   input  logic [STA_LO_W-1:0] sta_lo_i,
   input  logic [STA_HI_W-1:0] sta_hi_i,
   output logic              sta_acc_o,
   input  logic [BUS_W-1:0]  stb_i,
   input  logic              snap_i
);

   localparam int unsigned N_SUB    = CNT_W / BUS_W;
   localparam int unsigned SUB_W    = (N_SUB > 1) ? $clog2(N_SUB) : 1;
   localparam int unsigned ARM_ADDR = N_SUB;
   localparam int unsigned STA_ADDR = N_SUB + 1;
   localparam int unsigned STB_ADDR = N_SUB + 2;
   localparam int unsigned STA_USED = STA_LO_W + STA_HI_W;

   generate
      if (CNT_W % BUS_W != 0) begin : g_chk_div
         $error("CNT_W must be a multiple of BUS_W");
      end
      if (N_SUB < 2 || (N_SUB & (N_SUB - 1)) != 0) begin : g_chk_sub
         $error("counter must span a power-of-two number of sub-words, at least two");
      end
      if (STB_ADDR >= (1 << ADDR_W)) begin : g_chk_map
         $error("ADDR_W too small for the register map");
      end
      if (STA_USED > BUS_W) begin : g_chk_sta
         $error("status A fields exceed the bus width");
      end
   endgenerate

   // ---------------- address decode ----------------
   rsnap_tgt_e tgt;
   always_comb begin
      if (int'(addr_i) < N_SUB)          tgt = TGT_CNT;
      else if (int'(addr_i) == ARM_ADDR) tgt = TGT_ARM;
      else if (int'(addr_i) == STA_ADDR) tgt = TGT_STA;
      else if (int'(addr_i) == STB_ADDR) tgt = TGT_STB;
      else                               tgt = TGT_NONE;
   end

   logic [SUB_W-1:0] sub_idx;
   assign sub_idx = addr_i[SUB_W-1:0];

   logic cnt_cap;
   logic sta_cap;
   logic stb_load;
   assign cnt_cap = rd_en_i && (tgt == TGT_CNT) && (sub_idx == '0);
   assign sta_cap = rd_en_i && (tgt == TGT_ARM);

   generate
      if (SNAP_ACTIVE_HIGH) begin : g_snap_hi
         assign stb_load = snap_i;
      end else begin : g_snap_lo
         assign stb_load = !snap_i;
      end
   endgenerate

   assign cnt_acc_o = cnt_cap;
   assign sta_acc_o = sta_cap;

   // ---------------- counter and its snapshot ----------------
   logic [CNT_W-1:0] cnt_live;
   logic [CNT_W-1:0] cnt_snap;

   rsnap_counter #(
      .W              (CNT_W),
      .CLR_ON_CAPTURE (CNT_CLR_ON_READ)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (cnt_en_i),
      .capture_i (cnt_cap),
      .count_o   (cnt_live)
   );

   rsnap_buffer #(.W(CNT_W)) u_cnt_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (cnt_cap),
      .d_i    (cnt_live),
      .q_o    (cnt_snap)
   );

   // sub-word 0 bypasses the snapshot, the rest come from it
   logic [BUS_W-1:0] cnt_word [N_SUB];
   assign cnt_word[0] = cnt_live[BUS_W-1:0];
   for (genvar k = 1; k < N_SUB; k++) begin : g_sub
      assign cnt_word[k] = cnt_snap[k*BUS_W +: BUS_W];
   end

   // ---------------- status A: packed with reversed low field ----------------
   logic [BUS_W-1:0] sta_live;
   logic [BUS_W-1:0] sta_snap;
   for (genvar b = 0; b < STA_LO_W; b++) begin : g_rev
      assign sta_live[b] = sta_lo_i[STA_LO_W-1-b];
   end
   assign sta_live[STA_USED-1:STA_LO_W] = sta_hi_i;
   generate
      if (STA_USED < BUS_W) begin : g_sta_pad
         assign sta_live[BUS_W-1:STA_USED] = '0;
      end
   endgenerate

   rsnap_buffer #(.W(BUS_W)) u_sta_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (sta_cap),
      .d_i    (sta_live),
      .q_o    (sta_snap)
   );

   // ---------------- status B: external sample ----------------
   logic [BUS_W-1:0] stb_snap;
   rsnap_buffer #(.W(BUS_W)) u_stb_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (stb_load),
      .d_i    (stb_i),
      .q_o    (stb_snap)
   );

   // ---------------- arm register ----------------
   logic [BUS_W-1:0] arm_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         arm_q <= '0;
      else if (wr_en_i && tgt == TGT_ARM)  arm_q <= wdata_i;
   end

   // ---------------- readback ----------------
   logic [BUS_W-1:0] rd_mux;
   always_comb begin
      unique case (tgt)
         TGT_CNT: rd_mux = cnt_word[sub_idx];
         TGT_ARM: rd_mux = arm_q;
         TGT_STA: rd_mux = sta_snap;
         TGT_STB: rd_mux = stb_snap;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o    <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rdata_o    <= rd_en_i ? rd_mux : '0;
         rd_valid_o <= rd_en_i;
      end
   end

   // R2: data is zero outside the return cycle
   p_idle_data_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_valid_o |-> (rdata_o == '0));

   // R6, R7: one read request never raises both access pulses
   p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({cnt_acc_o, sta_acc_o}));

   // R4: the byte-0 read returns the same count the snapshot stored
   p_coherent_low_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_cap |=> (rdata_o == cnt_snap[BUS_W-1:0]));

endmodule

// File: tb/tb_rsnap_bank.sv
module tb_rsnap_bank;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rd_valid;
   logic       cnt_en = 1'b0;
   logic       cnt_acc;
   logic [3:0] sta_lo = '0;
   logic [2:0] sta_hi = '0;
   logic       sta_acc;
   logic [7:0] stb = '0;
   logic       snap = 1'b0;

   int n_chk = 0, n_fail = 0;
   int cnt_acc_seen = 0, sta_acc_seen = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   rsnap_bank dut (
      .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
      .cnt_en_i(cnt_en), .cnt_acc_o(cnt_acc), .sta_lo_i(sta_lo),
      .sta_hi_i(sta_hi), .sta_acc_o(sta_acc), .stb_i(stb), .snap_i(snap)
   );

   always @(posedge clk) begin
      if (rst_n && cnt_acc) cnt_acc_seen++;
      if (rst_n && sta_acc) sta_acc_seen++;
   end

   // {sta_lo, sta_hi, expected snapshot byte}
   localparam logic [14:0] STA_VEC [6] = '{
      {4'b0001, 3'b000, 8'h08},
      {4'b1000, 3'b111, 8'h71},
      {4'b1100, 3'b010, 8'h23},
      {4'b0110, 3'b101, 8'h56},
      {4'b1111, 3'b111, 8'h7F},
      {4'b0010, 3'b011, 8'h34}
   };

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
      chk("R2 valid", int'(rd_valid), 1);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int a0, s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", int'(rdata), 0);
      chk("R1 valid", int'(rd_valid), 0);
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), d);
         chk("R1 reg after reset", int'(d), 0);
      end
      @(negedge clk);
      chk("R2 idle data", int'(rdata), 0);

      // R3 R4: count 300, then read bytes
      cnt_en = 1'b1;
      repeat (300) @(negedge clk);
      cnt_en = 1'b0;
      a0 = cnt_acc_seen;
      rd(3'd0, d); chk("R4 byte0 live", int'(d), 8'h2C);
      chk("R6 pulse on addr0", cnt_acc_seen - a0, 1);
      rd(3'd1, d); chk("R4 byte1 snap", int'(d), 8'h01);
      rd(3'd2, d); chk("R4 byte2 snap", int'(d), 0);
      rd(3'd3, d); chk("R4 byte3 snap", int'(d), 0);
      chk("R6 no pulse on upper bytes", cnt_acc_seen - a0, 1);
      rd(3'd0, d); chk("R5 cleared at capture", int'(d), 0);
      rd(3'd1, d); chk("R4 snapshot reloaded", int'(d), 0);

      // R4 R5 coherency while counting
      cnt_en = 1'b1;
      repeat (599) @(negedge clk);
      rd(3'd0, d); chk("R3 count 600 low byte", int'(d), 8'h58);
      rd(3'd1, d); chk("R4 upper byte frozen", int'(d), 8'h02);
      cnt_en = 1'b0;
      rd(3'd0, d); chk("R5 restart from one", int'(d), 3);

      // R7 R8 table walk
      for (int i = 0; i < 6; i++) begin
         logic [14:0] v;
         v = STA_VEC[i];
         @(negedge clk);
         sta_lo = v[14:11]; sta_hi = v[10:8];
         s0 = sta_acc_seen;
         rd(3'd4, d);
         chk("R7 pulse on arm read", sta_acc_seen - s0, 1);
         sta_lo = ~v[14:11]; sta_hi = ~v[10:8];
         rd(3'd5, d);
         chk("R8 snapshot layout", int'(d), int'(v[7:0]));
         chk("R7 no pulse on status read", sta_acc_seen - s0, 1);
         rd(3'd5, d);
         chk("R7 status read does not reload", int'(d), int'(v[7:0]));
      end

      // R9 external sample
      @(negedge clk); snap = 1'b1; stb = 8'h11;
      @(negedge clk); stb = 8'h22;
      @(negedge clk); stb = 8'h33;
      @(negedge clk); snap = 1'b0; stb = 8'hFF;
      rd(3'd6, d); chk("R9 last sampled value", int'(d), 8'h33);
      @(negedge clk); snap = 1'b1; stb = 8'h44;
      @(negedge clk); snap = 1'b0; stb = 8'h99;
      rd(3'd6, d); chk("R9 single-cycle sample", int'(d), 8'h44);

      // R10 arm register and ignored writes
      wr(3'd4, 8'hA5);
      rd(3'd4, d); chk("R10 arm readback", int'(d), 8'hA5);
      wr(3'd6, 8'h00);
      rd(3'd6, d); chk("R10 write to status B ignored", int'(d), 8'h44);
      wr(3'd1, 8'hEE);
      rd(3'd1, d); chk("R10 write to counter ignored", int'(d), 0);
      rd(3'd7, d); chk("R2 unmapped reads zero", int'(d), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule